// File: doc/BRIEF.md
# Memory Decoder Commit Register Bank

This block is the programming face of a memory-expansion port. It holds a parameterized number of host-address-range decoders. Each decoder has a control word, a 64-bit base, a 64-bit size and a 64-bit extension value. In the switch build, the extension value is a target list of up to eight 8-bit port IDs. In the endpoint build, it is a skip amount. Every 64-bit value is reached as two 32-bit words over a simple register bus. Writes are strobed, and read data follows the address with no delay.

Software fills a decoder's fields and then sets its commit request bit. After a fixed number of cycles the decoder reports either committed or commit error. A commit fails when the decoder below it is not committed at the moment of evaluation, or when the size is zero. Decoders therefore come up in ascending index order. They are released in descending order by clearing the commit request. A lock bit pins a committed decoder until reset. A read-only capability word advertises the decoder count, the target count and two interleave address-range flags.

Top module: `mdec_regbank`

## Requirements
- R1: Word address 0 reads the capability word. Bits 3:0 hold NUM_DEC. Bits 11:4 hold the target count, which is TGT_COUNT in the switch build and 0 in the endpoint build. Bit 16 is set when interleave on address bits 11:8 is offered. Bit 17 is set when interleave on address bits 14:12 is offered. All other bits read 0.
- R2: After a synchronous active-low reset, every decoder is uncommitted. Its control word, base, size and extension all read 0, and `dec_committed` is 0.
- R3: Decoder d occupies word addresses 8*(d+1)+k. The offsets k are: 0 control, 1 base low, 2 base high, 3 size low, 4 size high, 5 extension low, 6 extension high. In the target list, way n sits at bits 8n+7:8n of the 64-bit value, so ways 4 to 7 are in the high word. The control word holds granularity in bits 3:0, ways in 7:4, lock in 8, commit request in 9, committed in 10, commit error in 11 and type-3 expander in 12.
- R4: A control write that raises the commit bit from 0 clears the error flag. Exactly COMMIT_LAT cycles after that write, the decoder shows either committed or commit error, and never both.
- R5: A decoder d>0 whose predecessor is not committed at evaluation time reports commit error, not committed.
- R6: A decoder whose 64-bit size is zero at evaluation time reports commit error.
- R7: While a decoder's commit bit is set, writes to its base, size, extension, granularity, ways and type bit are ignored.
- R8: Clearing the commit bit of a committed decoder releases it only when the next-higher decoder is not committed. Otherwise the write is ignored. A release clears both commit and committed.
- R9: The lock bit is set by writing 1 and cleared only by reset. While a committed decoder is locked, clearing its commit bit is ignored.
- R10: Any control write with the commit bit at 0 clears that decoder's commit error flag. If the commit is pending or failed, the same write also drops the request.
- R11: If decoder d is released in the same cycle that decoder d+1 completes its evaluation, the release takes effect and decoder d+1 reports commit error.
- R12: `dec_committed[d]` equals decoder d's committed bit. Committed is never set for decoder d unless decoder d-1 is also committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dec_committed | output | NUM_DEC | Committed flag of each decoder |

## Verification
Two functions can land in the same clock edge. One is the end of decoder d+1's commit countdown. The other is a software write that releases decoder d. The bench starts the commit of decoder 1 and then times the release write of decoder 0 so that the bank samples it exactly on the completion edge. The outcome is judged by reading both control words afterwards. Decoder 0 must read fully released, and decoder 1 must show commit error with no committed bit, which confirms that the successor's order check used the predecessor's next state.

// File: rtl/mdec_pkg.sv
// Package: shared control-word layout and register word offsets for the
// decoder commit register bank. Assumes a 32-bit register bus.
package mdec_pkg;

    localparam int DATA_W      = 32;
    localparam int CW_GRAN_LSB = 0;
    localparam int CW_WAYS_LSB = 4;
    localparam int CW_FIELD_W  = 4;
    localparam int CW_LOCK     = 8;
    localparam int CW_COMMIT   = 9;
    localparam int CW_DONE     = 10;
    localparam int CW_ERR      = 11;
    localparam int CW_TYPE3    = 12;

    localparam int SLOT_WORDS  = 8;
    localparam int WORD_IDX_W  = 3;

    typedef enum logic [WORD_IDX_W-1:0] {
        WD_CTRL    = 3'd0,
        WD_BASE_LO = 3'd1,
        WD_BASE_HI = 3'd2,
        WD_SIZE_LO = 3'd3,
        WD_SIZE_HI = 3'd4,
        WD_EXT_LO  = 3'd5,
        WD_EXT_HI  = 3'd6,
        WD_NONE    = 3'd7
    } word_e;

endpackage

// File: rtl/mdec_cap.sv
// Module: builds the read-only capability word from parameters.
// Assumes NUM_DEC fits in 4 bits and TGT_COUNT in 8 bits.
module mdec_cap #(
    parameter int NUM_DEC   = 4,
    parameter int TGT_COUNT = 8,
    parameter bit IS_SWITCH = 1'b1,
    parameter bit IL_LOW    = 1'b1,
    parameter bit IL_HIGH   = 1'b0
) (
    output logic [31:0] cap_word
);
    localparam logic [7:0] TGT_FIELD = IS_SWITCH ? 8'(TGT_COUNT) : 8'd0;

    // Pack the fixed capability fields.
    always_comb begin
        cap_word        = '0;
        cap_word[3:0]   = 4'(NUM_DEC);
        cap_word[11:4]  = TGT_FIELD;
        cap_word[16]    = IL_LOW;
        cap_word[17]    = IL_HIGH;
    end
endmodule

// File: rtl/mdec_reg64.sv
// Module: a 64-bit value written as two halves, guarded by an open flag.
// Assumes at most one half is written per cycle by the caller's decode.
module mdec_reg64 #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] value
);
    // Hold each half; accept writes only while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            if (open && wr_lo) value[HALF_W-1:0]        <= wdata;
            if (open && wr_hi) value[2*HALF_W-1:HALF_W] <= wdata;
        end
    end
endmodule

// File: rtl/mdec_slot.sv
// Module: one decoder: control word, base, size, extension and the commit
// evaluation timer. Assumes prev_ok is the predecessor's committed next
// state (1 for decoder 0) and next_done the successor's registered committed
// bit (0 for the last decoder).
module mdec_slot
    import mdec_pkg::*;
#(
    parameter int COMMIT_LAT = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WORD_IDX_W-1:0]        wr_word,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         prev_ok,
    input  logic                         next_done,
    output logic                         done_nxt,
    output logic                         commit_o,
    output logic                         done_o,
    output logic                         err_o,
    output logic                         lock_o,
    output logic [SLOT_WORDS-1:0][DATA_W-1:0] rd_words
);
    localparam int CNT_W = $clog2(COMMIT_LAT + 1);

    logic                  commit_q, done_q, err_q, lock_q, type3_q;
    logic [CW_FIELD_W-1:0] gran_q, ways_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [63:0]           base_v, size_v, ext_v;
    logic                  ctrl_we, start, rel_req, release_ok, done_evt, pass;

    // Decode which word of this decoder is being written.
    assign ctrl_we = wr_en && (wr_word == WD_CTRL);

    // Commit request edge and release request from the control write.
    assign start   = ctrl_we && !commit_q &&  wdata[CW_COMMIT];
    assign rel_req = ctrl_we &&  commit_q && !wdata[CW_COMMIT];

    // A committed decoder may drop only if unlocked and topmost.
    assign release_ok = done_q && !lock_q && !next_done;

    // Evaluation happens on the last timer count unless cancelled.
    assign done_evt = (cnt_q == CNT_W'(1)) && !rel_req;
    assign pass     = prev_ok && (size_v != 64'd0);

    // Next committed state, offered to the successor's order check.
    assign done_nxt = (rel_req && release_ok) ? 1'b0 :
                      (done_evt && pass)      ? 1'b1 : done_q;

    // Control word state: commit, status flags, timer and fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            lock_q   <= 1'b0;
            type3_q  <= 1'b0;
            gran_q   <= '0;
            ways_q   <= '0;
            cnt_q    <= '0;
        end else begin
            done_q <= done_nxt;
            if (start) begin
                commit_q <= 1'b1;
                cnt_q    <= CNT_W'(COMMIT_LAT);
            end else if (rel_req && (!done_q || release_ok)) begin
                commit_q <= 1'b0;
                cnt_q    <= '0;
            end else if (cnt_q != '0) begin
                cnt_q    <= cnt_q - CNT_W'(1);
            end
            if (ctrl_we && !wdata[CW_COMMIT]) err_q <= 1'b0;
            else if (start)                   err_q <= 1'b0;
            else if (done_evt && !pass)       err_q <= 1'b1;
            if (ctrl_we && wdata[CW_LOCK]) lock_q <= 1'b1;
            if (ctrl_we && !commit_q) begin
                gran_q  <= wdata[CW_GRAN_LSB +: CW_FIELD_W];
                ways_q  <= wdata[CW_WAYS_LSB +: CW_FIELD_W];
                type3_q <= wdata[CW_TYPE3];
            end
        end
    end

    mdec_reg64 #(.HALF_W(DATA_W)) u_base (
        .clk(clk), .rst_n(rst_n), .open(!commit_q),
        .wr_lo(wr_en && wr_word == WD_BASE_LO),
        .wr_hi(wr_en && wr_word == WD_BASE_HI),
        .wdata(wdata), .value(base_v)
    );

    mdec_reg64 #(.HALF_W(DATA_W)) u_size (
        .clk(clk), .rst_n(rst_n), .open(!commit_q),
        .wr_lo(wr_en && wr_word == WD_SIZE_LO),
        .wr_hi(wr_en && wr_word == WD_SIZE_HI),
        .wdata(wdata), .value(size_v)
    );

    mdec_reg64 #(.HALF_W(DATA_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .open(!commit_q),
        .wr_lo(wr_en && wr_word == WD_EXT_LO),
        .wr_hi(wr_en && wr_word == WD_EXT_HI),
        .wdata(wdata), .value(ext_v)
    );

    // Assemble the readable words of this decoder.
    always_comb begin
        rd_words             = '0;
        rd_words[WD_CTRL][CW_GRAN_LSB +: CW_FIELD_W] = gran_q;
        rd_words[WD_CTRL][CW_WAYS_LSB +: CW_FIELD_W] = ways_q;
        rd_words[WD_CTRL][CW_LOCK]   = lock_q;
        rd_words[WD_CTRL][CW_COMMIT] = commit_q;
        rd_words[WD_CTRL][CW_DONE]   = done_q;
        rd_words[WD_CTRL][CW_ERR]    = err_q;
        rd_words[WD_CTRL][CW_TYPE3]  = type3_q;
        rd_words[WD_BASE_LO] = base_v[31:0];
        rd_words[WD_BASE_HI] = base_v[63:32];
        rd_words[WD_SIZE_LO] = size_v[31:0];
        rd_words[WD_SIZE_HI] = size_v[63:32];
        rd_words[WD_EXT_LO]  = ext_v[31:0];
        rd_words[WD_EXT_HI]  = ext_v[63:32];
    end

    assign commit_o = commit_q;
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign lock_o   = lock_q;
endmodule

// File: rtl/mdec_regbank.sv
// Module: top of the decoder commit register bank. Decodes the register
// bus, chains the ordering signals between decoders and muxes read data.
// Assumes one write per cycle and combinational reads.
module mdec_regbank
    import mdec_pkg::*;
#(
    parameter int NUM_DEC    = 4,
    parameter int TGT_COUNT  = 8,
    parameter bit IS_SWITCH  = 1'b1,
    parameter bit IL_LOW     = 1'b1,
    parameter bit IL_HIGH    = 1'b0,
    parameter int COMMIT_LAT = 6,
    parameter int ADDR_W     = $clog2((NUM_DEC + 1) * SLOT_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_DEC-1:0] dec_committed
);
    localparam int BLK_W = ADDR_W - WORD_IDX_W;

    logic [BLK_W-1:0]      blk;
    logic [WORD_IDX_W-1:0] word;
    logic [31:0]           cap_word;
    logic [NUM_DEC-1:0]    done_nxt_v, done_v, commit_v, err_v, lock_v;
    logic [NUM_DEC-1:0][SLOT_WORDS-1:0][DATA_W-1:0] slot_words;

    // Split the word address into block and word offset.
    assign blk  = reg_addr[ADDR_W-1:WORD_IDX_W];
    assign word = reg_addr[WORD_IDX_W-1:0];

    mdec_cap #(
        .NUM_DEC(NUM_DEC), .TGT_COUNT(TGT_COUNT), .IS_SWITCH(IS_SWITCH),
        .IL_LOW(IL_LOW), .IL_HIGH(IL_HIGH)
    ) u_cap (
        .cap_word(cap_word)
    );

    for (genvar d = 0; d < NUM_DEC; d++) begin : g_slot
        logic prev_ok, next_done;
        if (d == 0) begin : g_first
            assign prev_ok = 1'b1;
        end else begin : g_mid
            assign prev_ok = done_nxt_v[d-1];
        end
        if (d == NUM_DEC - 1) begin : g_last
            assign next_done = 1'b0;
        end else begin : g_below
            assign next_done = done_v[d+1];
        end

        mdec_slot #(.COMMIT_LAT(COMMIT_LAT)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && (blk == BLK_W'(d + 1))),
            .wr_word(word), .wdata(reg_wdata),
            .prev_ok(prev_ok), .next_done(next_done),
            .done_nxt(done_nxt_v[d]),
            .commit_o(commit_v[d]), .done_o(done_v[d]),
            .err_o(err_v[d]), .lock_o(lock_v[d]),
            .rd_words(slot_words[d])
        );
    end

    // Select read data by block: capability, a decoder, or zero.
    always_comb begin
        reg_rdata = '0;
        if (blk == '0) reg_rdata = cap_word;
        for (int d = 0; d < NUM_DEC; d++) begin
            if (blk == BLK_W'(d + 1)) reg_rdata = slot_words[d][word];
        end
    end

    assign dec_committed = done_v;
endmodule

// File: rtl/mdec_regbank_chk.sv
// Module: assertion checker for the decoder commit register bank, bound to
// the top. Assumes COMMIT_LAT fits in a 32-bit counter.
module mdec_regbank_chk #(
    parameter int NUM_DEC    = 4,
    parameter int COMMIT_LAT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DEC-1:0] commit_v,
    input logic [NUM_DEC-1:0] done_v,
    input logic [NUM_DEC-1:0] err_v,
    input logic [NUM_DEC-1:0] lock_v,
    input logic [NUM_DEC-1:0] dec_committed
);
    for (genvar d = 0; d < NUM_DEC; d++) begin : g_chk
        logic [31:0] pend_cnt;

        // Count cycles a request waits without an outcome.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_cnt <= '0;
            else if (commit_v[d] && !done_v[d] && !err_v[d]) pend_cnt <= pend_cnt + 32'd1;
            else pend_cnt <= '0;
        end

        // R4
        bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_cnt <= 32'(COMMIT_LAT));

        // R4
        exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done_v[d] || err_v[d]) |-> pend_cnt == 32'(COMMIT_LAT));

        // R4
        excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(done_v[d] && err_v[d]));

        // R12
        need_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_v[d] || err_v[d]) |-> commit_v[d]);

        // R12
        port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dec_committed[d] == done_v[d]);

        // R9
        lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done_v[d] && lock_v[d]) |=> done_v[d]);

        if (d > 0) begin : g_ord
            // R12
            ord_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done_v[d] |-> done_v[d-1]);
        end
    end
endmodule

bind mdec_regbank mdec_regbank_chk #(
    .NUM_DEC(NUM_DEC), .COMMIT_LAT(COMMIT_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .commit_v(commit_v), .done_v(done_v),
    .err_v(err_v), .lock_v(lock_v), .dec_committed(dec_committed)
);

// File: tb/mdec_regbank_bench.sv
// Directed bench for the decoder commit register bank.
module mdec_regbank_bench;
    localparam int NUM_DEC = 4;
    localparam int LAT     = 6;
    localparam int ADDR_W  = $clog2((NUM_DEC + 1) * 8);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NUM_DEC-1:0] dec_committed;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mdec_regbank #(.NUM_DEC(NUM_DEC), .COMMIT_LAT(LAT)) u_mdec_regbank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dec_committed(dec_committed)
    );

    function automatic int ra(input int d, input int k);
        return (d + 1) * 8 + k;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = ADDR_W'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);          chk("R1 capability", v, 32'h0001_0084);
        rd(ra(0, 0), v);   chk("R2 ctrl0 reset", v, 32'h0);
        rd(ra(3, 1), v);   chk("R2 base3 reset", v, 32'h0);
        rd(ra(2, 6), v);   chk("R2 ext2 reset", v, 32'h0);
        chk("R2 committed port", 32'(dec_committed), 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(ra(0, 1), 32'h1000_0000);
        wr(ra(0, 2), 32'h0000_0002);
        wr(ra(0, 3), 32'h4000_0000);
        wr(ra(0, 5), 32'h0302_0100);
        wr(ra(0, 6), 32'h0706_0504);
        wr(ra(0, 0), 32'h0000_1012);
        rd(ra(0, 2), v);  chk("R3 base high", v, 32'h2);
        rd(ra(0, 3), v);  chk("R3 size low", v, 32'h4000_0000);
        rd(ra(0, 6), v);  chk("R3 way7 byte", {24'h0, v[31:24]}, 32'h07);
        rd(ra(0, 5), v);  chk("R3 way1 byte", {24'h0, v[15:8]}, 32'h01);
        rd(ra(0, 0), v);  chk("R3 ctrl fields", v, 32'h0000_1012);
    endtask

    task automatic t_commit_ok();
        logic [31:0] v;
        wr(ra(0, 0), 32'h0000_1212);
        idle(LAT - 1);
        rd(ra(0, 0), v);  chk("R4 not yet committed", v, 32'h0000_1212);
        idle(1);
        rd(ra(0, 0), v);  chk("R4 committed at bound", v, 32'h0000_1612);
        chk("R12 port d0", 32'(dec_committed), 32'h1);
    endtask

    task automatic t_protect();
        logic [31:0] v;
        wr(ra(0, 1), 32'h0000_DEAD);
        wr(ra(0, 6), 32'hFFFF_FFFF);
        wr(ra(0, 0), 32'h0000_0277);
        rd(ra(0, 1), v);  chk("R7 base locked", v, 32'h1000_0000);
        rd(ra(0, 6), v);  chk("R7 ext locked", v, 32'h0706_0504);
        rd(ra(0, 0), v);  chk("R7 ctrl fields kept", v, 32'h0000_1612);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wr(ra(2, 3), 32'h0000_0100);
        wr(ra(2, 0), 32'h0000_0200);
        idle(LAT);
        rd(ra(2, 0), v);  chk("R5 out of order error", v, 32'h0000_0A00);
        wr(ra(2, 0), 32'h0);
        rd(ra(2, 0), v);  chk("R10 error cleared", v, 32'h0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(ra(1, 0), 32'h0000_0200);
        idle(LAT);
        rd(ra(1, 0), v);  chk("R6 zero size error", v, 32'h0000_0A00);
        wr(ra(1, 0), 32'h0);
        rd(ra(1, 0), v);  chk("R10 error cleared d1", v, 32'h0);
    endtask

    task automatic t_release();
        logic [31:0] v;
        wr(ra(1, 3), 32'h0000_0100);
        wr(ra(1, 0), 32'h0000_0200);
        idle(LAT);
        rd(ra(1, 0), v);  chk("R5 in order commit", v, 32'h0000_0600);
        chk("R12 port d0 d1", 32'(dec_committed), 32'h3);
        wr(ra(0, 0), 32'h0000_1012);
        rd(ra(0, 0), v);  chk("R8 lower release ignored", v, 32'h0000_1612);
        wr(ra(1, 0), 32'h0);
        rd(ra(1, 0), v);  chk("R8 top release", v, 32'h0);
        wr(ra(1, 3), 32'h0);
        rd(ra(1, 3), v);  chk("R8 size zeroed", v, 32'h0);
        chk("R8 port after release", 32'(dec_committed), 32'h1);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(ra(0, 0), 32'h0000_1312);
        rd(ra(0, 0), v);  chk("R9 lock set", v, 32'h0000_1712);
        wr(ra(0, 0), 32'h0000_1012);
        rd(ra(0, 0), v);  chk("R9 locked release ignored", v, 32'h0000_1712);
        do_reset();
        rd(ra(0, 0), v);  chk("R2 ctrl after reset", v, 32'h0);
        rd(ra(0, 1), v);  chk("R2 base after reset", v, 32'h0);
        chk("R2 port after reset", 32'(dec_committed), 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(ra(0, 3), 32'h0000_0010);
        wr(ra(0, 0), 32'h0000_0200);
        idle(LAT);
        wr(ra(1, 3), 32'h0000_0010);
        wr(ra(1, 0), 32'h0000_0200);
        idle(LAT - 1);
        wr(ra(0, 0), 32'h0);
        rd(ra(0, 0), v);  chk("R11 release wins", v, 32'h0);
        rd(ra(1, 0), v);  chk("R11 successor error", v, 32'h0000_0A00);
        chk("R11 port", 32'(dec_committed), 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fields();
        t_commit_ok();
        t_protect();
        t_order();
        t_zero();
        t_release();
        t_lock();
        t_collide();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule